// File: doc/BRIEF.md
# Spare-Slot Byte Substitution Stage

This block is the byte-substitution step of a 128-bit block-cipher round. It holds seventeen substitution slots for the sixteen byte lanes of the state. One slot is always left idle; this is the "hole". While a slot is the hole, an outside process may rebuild or exchange that slot without stopping encryption. A steering network sends each input lane to an active slot. A second network collects the slot results back into lane order. The substituted word is registered once, and no further register sits between the substitution and the column-mixing logic that follows.

A move command picks a new hole index. A small controller applies the move and spends exactly one stall cycle doing it. Upstream logic must present the same word again while `stall` is high. In every other cycle the stage accepts one word per clock. A move request that arrives during the stall cycle is stored and carried out after a single normal cycle.

Controller states: `ST_RUN` (normal flow, no request stored), `ST_SHIFT` (the one stall cycle, in which the new hole position takes effect), and `ST_ARMED` (normal flow with one stored request). Transitions: RUN→SHIFT on an in-range request; RUN→RUN otherwise; SHIFT→ARMED when an in-range request arrives during the stall; SHIFT→RUN otherwise; ARMED→SHIFT always, applying the stored index.

Top module: `spare_sbox_stage`

## Requirements
- R1: After reset is released, `out_valid`, `stall` and `hole_ack` are low, `out_data` is all zeros, and the hole sits at slot 16.
- R2: One cycle after a word is accepted, `out_valid` is high and every byte of `out_data` (lane i at bits 8i+7..8i) equals the standard AES forward substitution of the same byte of `in_data`. This holds for every hole position from 0 to 16.
- R3: With the hole at index h, lane i is served by slot i when i < h and by slot i+1 when i ≥ h. The hole slot receives a zero input, and its result is unused.
- R4: An in-range request (`hole_idx` 0 to 16) sampled in `ST_RUN` makes `stall` and `hole_ack` high for exactly the next cycle. The new hole is in use from the cycle after that.
- R5: A word presented while `stall` is high is not accepted, and `out_valid` is low in the following cycle. Each move therefore leaves exactly one bubble.
- R6: In any cycle with `stall` low, a word with `in_valid` high is accepted, so the stage takes one word per clock outside stall cycles.
- R7: A request with `hole_idx` above 16 is ignored: no stall, no acknowledge, no state change.
- R8: An in-range request sampled during the stall cycle is stored. One normal cycle follows, then a second stall cycle applies the stored index. A request sampled in that normal (`ST_ARMED`) cycle is ignored.
- R9: `stall` is never high in two consecutive cycles.
- R10: While no word is accepted, `out_data` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_data | input | 128 | Input state, lane i at bits 8i+7..8i |
| stall | output | 1 | High during a hole-move cycle; the input is not taken |
| out_valid | output | 1 | Substituted word valid |
| out_data | output | 128 | Substituted state, same lane order |
| hole_req | input | 1 | Request to move the hole |
| hole_idx | input | 5 | Target slot index, 0 to 16 |
| hole_ack | output | 1 | High in the cycle the move takes effect |

## Verification
Traffic is streamed while the hole is walked through every slot from 0 to 16. Each output byte is compared with an independent substitution model. A wrong lane-to-slot offset on either side of the hole would give wrong bytes at one of these positions, and an idle slot leaking into the result would corrupt a lane. Moves are requested back to back, including during the stall and during the armed cycle. This catches a second stall cycle, a lost stored request, or a request taken that should have been dropped. Out-of-range indices 17 and 31 must cause no stall at all. Idle gaps check that the output register holds its value and does not reload.

// File: rtl/spare_sbox_pkg.sv
package spare_sbox_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SHIFT = 2'd1,
        ST_ARMED = 2'd2
    } hole_state_e;

    // product in GF(2^8) modulo x^8+x^4+x^3+x+1
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] x;
        acc = 8'h00;
        x   = a;
        for (int k = 0; k < 8; k++) begin
            if (b[k]) acc = acc ^ x;
            x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
        end
        return acc;
    endfunction

    // inverse as a^254 built from successive squares 2..128
    function automatic logic [7:0] gf_inv_sq(input logic [7:0] a);
        logic [7:0] sq;
        logic [7:0] r;
        sq = a;
        r  = 8'h01;
        for (int k = 1; k < 8; k++) begin
            sq = gf_mul(sq, sq);
            r  = gf_mul(r, sq);
        end
        return r;
    endfunction

    // inverse as (a^127)^2
    function automatic logic [7:0] gf_inv_half(input logic [7:0] a);
        logic [7:0] sq;
        logic [7:0] r;
        sq = a;
        r  = a;
        for (int k = 1; k < 7; k++) begin
            sq = gf_mul(sq, sq);
            r  = gf_mul(r, sq);
        end
        return gf_mul(r, r);
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
        return (v << n) | (v >> (8 - n));
    endfunction

    function automatic logic [7:0] affine_rot(input logic [7:0] v);
        return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
    endfunction

    function automatic logic [7:0] affine_bit(input logic [7:0] v);
        logic [7:0] r;
        for (int k = 0; k < 8; k++) begin
            r[k] = v[k] ^ v[(k + 4) % 8] ^ v[(k + 5) % 8] ^ v[(k + 6) % 8] ^ v[(k + 7) % 8];
        end
        return r ^ 8'h63;
    endfunction

endpackage

// File: rtl/sbox_slot.sv
module sbox_slot #(
    parameter int VARIANT = 0
) (
    input  logic [7:0] din,
    output logic [7:0] dout
);
    import spare_sbox_pkg::*;

    // two functionally equal formulations, placed alternately over the slots
    generate
        if (VARIANT == 0) begin : g_sq
            always_comb dout = affine_rot(gf_inv_sq(din));
        end else begin : g_half
            always_comb dout = affine_bit(gf_inv_half(din));
        end
    endgenerate

endmodule

// File: rtl/spare_lane_router.sv
module spare_lane_router #(
    parameter int LANES = 16,
    parameter int W     = 8,
    localparam int SLOTS = LANES + 1,
    localparam int IDXW  = $clog2(SLOTS)
) (
    input  logic [IDXW-1:0]             hole,
    input  logic [LANES-1:0][W-1:0]     lane_in,
    output logic [SLOTS-1:0][W-1:0]     slot_in,
    input  logic [SLOTS-1:0][W-1:0]     slot_out,
    output logic [LANES-1:0][W-1:0]     lane_out
);

    // forward steering: slots below the hole take their own lane,
    // slots above it take the lane one below
    generate
        for (genvar s = 0; s < SLOTS; s++) begin : g_fwd
            localparam int SAME = (s < LANES) ? s : LANES - 1;
            localparam int LOW  = (s > 0) ? s - 1 : 0;
            always_comb begin
                if (IDXW'(s) == hole) begin
                    slot_in[s] = '0;
                end else if (IDXW'(s) < hole) begin
                    slot_in[s] = lane_in[SAME];
                end else begin
                    slot_in[s] = lane_in[LOW];
                end
            end
        end

        // return path back into lane order
        for (genvar i = 0; i < LANES; i++) begin : g_ret
            always_comb begin
                if (IDXW'(i) < hole) begin
                    lane_out[i] = slot_out[i];
                end else begin
                    lane_out[i] = slot_out[i+1];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/spare_hole_fsm.sv
module spare_hole_fsm #(
    parameter int SLOTS = 17,
    localparam int IDXW = $clog2(SLOTS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic [IDXW-1:0] req_idx,
    output logic [IDXW-1:0] hole,
    output logic            stall,
    output logic            ack
);
    import spare_sbox_pkg::*;

    localparam logic [IDXW-1:0] TOP_IDX = IDXW'(SLOTS - 1);

    hole_state_e     st_q, st_n;
    logic [IDXW-1:0] hole_q, hole_n;
    logic [IDXW-1:0] pend_q, pend_n;
    logic            req_ok;

    assign req_ok = req && (req_idx <= TOP_IDX);
    assign hole   = hole_q;

    always_comb begin
        st_n   = st_q;
        hole_n = hole_q;
        pend_n = pend_q;
        unique case (st_q)
            ST_RUN: begin
                if (req_ok) begin
                    st_n   = ST_SHIFT;
                    hole_n = req_idx;
                end
            end
            ST_SHIFT: begin
                if (req_ok) begin
                    st_n   = ST_ARMED;
                    pend_n = req_idx;
                end else begin
                    st_n = ST_RUN;
                end
            end
            ST_ARMED: begin
                st_n   = ST_SHIFT;
                hole_n = pend_q;
            end
            default: st_n = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_RUN;
            hole_q <= TOP_IDX;
            pend_q <= '0;
        end else begin
            st_q   <= st_n;
            hole_q <= hole_n;
            pend_q <= pend_n;
        end
    end

    always_comb begin
        stall = 1'b0;
        ack   = 1'b0;
        unique case (st_q)
            ST_SHIFT: begin
                stall = 1'b1;
                ack   = 1'b1;
            end
            ST_RUN, ST_ARMED: begin
                stall = 1'b0;
                ack   = 1'b0;
            end
            default: begin
                stall = 1'b0;
                ack   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/spare_sbox_stage.sv
module spare_sbox_stage #(
    parameter int LANES = 16,
    parameter int IDXW  = $clog2(LANES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [LANES*8-1:0]   in_data,
    output logic                 stall,
    output logic                 out_valid,
    output logic [LANES*8-1:0]   out_data,
    input  logic                 hole_req,
    input  logic [IDXW-1:0]      hole_idx,
    output logic                 hole_ack
);

    localparam int SLOTS = LANES + 1;

    logic [IDXW-1:0]           hole;
    logic [LANES-1:0][7:0]     lane_in;
    logic [LANES-1:0][7:0]     lane_out;
    logic [SLOTS-1:0][7:0]     slot_in;
    logic [SLOTS-1:0][7:0]     slot_out;
    logic                      take;

    assign lane_in = in_data;
    assign take    = in_valid && !stall;

    spare_hole_fsm #(.SLOTS(SLOTS)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (hole_req),
        .req_idx (hole_idx),
        .hole    (hole),
        .stall   (stall),
        .ack     (hole_ack)
    );

    spare_lane_router #(.LANES(LANES), .W(8)) u_route (
        .hole     (hole),
        .lane_in  (lane_in),
        .slot_in  (slot_in),
        .slot_out (slot_out),
        .lane_out (lane_out)
    );

    generate
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            sbox_slot #(.VARIANT(s % 2)) u_sb (
                .din  (slot_in[s]),
                .dout (slot_out[s])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= take;
            if (take) out_data <= lane_out;
        end
    end

endmodule

// File: rtl/spare_sbox_stage_chk.sv
module spare_sbox_stage_chk #(
    parameter int IDXW   = 5,
    parameter int MAXIDX = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            stall,
    input logic            out_valid,
    input logic            hole_req,
    input logic [IDXW-1:0] hole_idx,
    input logic            hole_ack
);

    localparam logic [IDXW-1:0] MAXV = IDXW'(MAXIDX);

    a_r9_single_stall: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    a_r5_one_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !out_valid);

    a_r6_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !stall) |=> out_valid);

    a_r7_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
        (hole_req && (hole_idx > MAXV) && !stall && !$past(stall)) |=> !stall);

    a_r4_move_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (hole_req && (hole_idx <= MAXV) && !stall && !$past(stall)) |=> (stall && hole_ack));

    a_r8_stored_move: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && hole_req && (hole_idx <= MAXV)) |=> !stall ##1 stall);

endmodule

bind spare_sbox_stage spare_sbox_stage_chk #(.IDXW(IDXW), .MAXIDX(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .stall     (stall),
    .out_valid (out_valid),
    .hole_req  (hole_req),
    .hole_idx  (hole_idx),
    .hole_ack  (hole_ack)
);

// File: tb/test_spare_sbox_stage.sv
`timescale 1ns/1ps
module test_spare_sbox_stage;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] in_data = '0;
    logic         stall;
    logic         out_valid;
    logic [127:0] out_data;
    logic         hole_req = 1'b0;
    logic [4:0]   hole_idx = '0;
    logic         hole_ack;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    spare_sbox_stage i_spare_sbox_stage (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .stall(stall), .out_valid(out_valid), .out_data(out_data),
        .hole_req(hole_req), .hole_idx(hole_idx), .hole_ack(hole_ack)
    );

    // reference substitution: brute-force inverse search
    logic [7:0] ref_sb [256];

    function automatic int poly_mod(input int a, input int b);
        int p = 0;
        for (int k = 0; k < 8; k++) if ((b >> k) & 1) p = p ^ (a << k);
        for (int k = 15; k >= 8; k--) if ((p >> k) & 1) p = p ^ (32'h11b << (k - 8));
        return p;
    endfunction

    initial begin
        for (int x = 0; x < 256; x++) begin
            int inv = 0;
            logic [7:0] b;
            logic [7:0] s;
            for (int y = 1; y < 256; y++) if (poly_mod(x, y) == 1) inv = y;
            b = inv[7:0];
            for (int k = 0; k < 8; k++)
                s[k] = b[k] ^ b[(k+4)%8] ^ b[(k+5)%8] ^ b[(k+6)%8] ^ b[(k+7)%8];
            ref_sb[x] = s ^ 8'h63;
        end
    end

    function automatic logic [127:0] ref_sub(input logic [127:0] d);
        logic [127:0] r;
        for (int i = 0; i < 16; i++) r[8*i +: 8] = ref_sb[d[8*i +: 8]];
        return r;
    endfunction

    // behavioural model state
    int           m_st = 0;       // 0 normal, 1 stall cycle, 2 normal with stored move
    bit           e_stall = 0;
    bit           e_ov = 0;
    logic [127:0] e_od = '0;
    bit           prev_stall = 0;

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input bit iv, input logic [127:0] d, input bit rq, input logic [4:0] ix,
                        input string tag, output bit taken);
        bit ok_req;
        @(negedge clk);
        chk(out_valid === e_ov, {tag, " R5 R6 out_valid"}, 128'(out_valid), 128'(e_ov));
        chk(out_data === e_od, {tag, " R2 R3 R10 out_data"}, out_data, e_od);
        chk(stall === e_stall, {tag, " R4 stall"}, 128'(stall), 128'(e_stall));
        chk(hole_ack === e_stall, {tag, " R4 hole_ack"}, 128'(hole_ack), 128'(e_stall));
        chk(!(prev_stall && stall), {tag, " R9 double stall"}, 128'(stall), 128'(0));
        prev_stall = stall;
        in_valid = iv;
        in_data  = d;
        hole_req = rq;
        hole_idx = ix;
        taken  = iv && !e_stall;
        ok_req = rq && (ix <= 5'd16);
        e_ov   = taken;
        if (taken) e_od = ref_sub(d);
        case (m_st)
            0: m_st = ok_req ? 1 : 0;
            1: m_st = ok_req ? 2 : 0;
            default: m_st = 1;
        endcase
        e_stall = (m_st == 1);
        @(posedge clk);
    endtask

    // present one word until accepted; request only with the first try
    task automatic send(input logic [127:0] d, input bit rq, input logic [4:0] ix, input string tag);
        bit taken = 0;
        bit r = rq;
        while (!taken) begin
            step(1'b1, d, r, ix, tag, taken);
            r = 1'b0;
        end
    endtask

    task automatic idle(input int n, input string tag);
        bit t;
        for (int k = 0; k < n; k++) step(1'b0, {4{$urandom()}}, 1'b0, 5'd0, tag, t);
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    initial begin
        bit t;
        logic [127:0] lanes;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(out_valid === 1'b0 && stall === 1'b0 && hole_ack === 1'b0, "R1 controls",
            {125'd0, out_valid, stall, hole_ack}, 128'd0);
        chk(out_data === '0, "R1 out_data", out_data, 128'd0);

        // R2 R6: full-rate stream with the hole at its reset slot 16
        send(128'd0, 0, 0, "R2 zeros");
        send({16{8'hff}}, 0, 0, "R2 ones");
        for (int i = 0; i < 16; i++) lanes[8*i +: 8] = 8'(i * 17 + 3);
        send(lanes, 0, 0, "R3 distinct lanes");
        for (int k = 0; k < 12; k++) send(rnd128(), 0, 0, "R6 stream");

        // R3 R4 R5: walk the hole through every slot with traffic
        for (int h = 0; h <= 16; h++) begin
            send(rnd128(), 1'b1, 5'(h), "R4 move");
            send(lanes, 0, 0, "R3 after move");
            for (int k = 0; k < 4; k++) send(rnd128(), 0, 0, "R5 post-move");
        end

        // R7: out-of-range requests
        send(rnd128(), 1'b1, 5'd17, "R7 idx17");
        send(rnd128(), 1'b1, 5'd31, "R7 idx31");
        send(rnd128(), 0, 0, "R7 after");

        // R8: request during stall is stored, request in armed cycle dropped
        step(1'b1, rnd128(), 1'b1, 5'd4, "R8 first", t);
        step(1'b1, rnd128(), 1'b1, 5'd9, "R8 during stall", t);
        step(1'b1, rnd128(), 1'b1, 5'd2, "R8 armed ignored", t);
        for (int k = 0; k < 5; k++) send(lanes, 0, 0, "R8 after");
        // request with the same index
        send(rnd128(), 1'b1, 5'd9, "R4 same index");
        for (int k = 0; k < 3; k++) send(rnd128(), 0, 0, "R2 tail");

        // R10: output holds over idle cycles
        idle(4, "R10 idle");
        send(rnd128(), 0, 0, "R10 resume");
        idle(2, "R10 idle end");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule